// File: doc/BRIEF.md
# Dot-Inversion Channel-Pair Polarity Router

This block drives the polarity control of a dot-inversion column driver. The analog side is built from channel pairs. In each pair, one converter handles only voltages below the common level and the other handles only voltages above it. The polarity of a data line therefore cannot be flipped by changing what a converter does. Instead, the router exchanges the two subpixel codes of the pair on their way into the converters. It also tells the output stage to exchange the two buffer outputs on their way to the column lines. Because of this, each converter decodes exactly the code width: a 10-bit code needs a 10-bit decoder, with no extra sign bit.

Polarity changes on every line and also from one frame to the next. A small state machine holds the line polarity in one of two states:

- `POL_NORMAL`: the odd line is driven negative and the even line is driven positive. Codes and outputs keep their order.
- `POL_CROSSED`: both codes and both outputs are exchanged.

There are two transitions:

- `T_LINE`, taken on a line strobe, moves to the other state.
- `T_FRAME`, taken on a frame strobe, first inverts the frame's starting polarity and then enters the state given by that new starting polarity.

The frame strobe wins when both strobes arrive together. Each strobe also captures every pair's input codes into registers on the same edge as the state update. A code and its routing therefore always belong to the same line.

Top module: `dotinv_pair_router`

## Requirements
- R1: After reset, `pol_o` is 0, every bit of `out_swap_o` is 0, and all code outputs are 0.
- R2: A line strobe without a frame strobe inverts `pol_o`. The change is visible from the clock edge that samples the strobe.
- R3: A frame strobe inverts the stored frame-start polarity and sets `pol_o` to the new value. The first frame strobe after reset gives 1, the next gives 0, and so on. When both strobes are high together, the frame strobe takes priority.
- R4: While `pol_o` is 0, pair p's negative-converter code equals its captured odd code and its positive-converter code equals its captured even code.
- R5: While `pol_o` is 1, pair p's negative-converter code equals its captured even code and its positive-converter code equals its captured odd code.
- R6: Every bit of `out_swap_o` equals `pol_o`. A 1 tells the output stage that the odd column takes the positive buffer.
- R7: In a cycle with neither strobe, a change on the code inputs affects neither the polarity nor any code output.
- R8: Each converter code is a full CODE_W-bit copy of one input code. The extreme values 0 and 2^CODE_W-1 pass unaltered, and each pair is routed only from its own two codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb_i | input | 1 | One-cycle pulse at each line start |
| frame_stb_i | input | 1 | One-cycle pulse at each frame start |
| odd_codes_i | input | NUM_PAIRS*CODE_W | Odd-channel codes; pair p at bits [p*CODE_W +: CODE_W] |
| even_codes_i | input | NUM_PAIRS*CODE_W | Even-channel codes; same packing |
| pol_o | output | 1 | Line polarity flag (0 = normal order) |
| neg_codes_o | output | NUM_PAIRS*CODE_W | Codes to the negative-only converters |
| pos_codes_o | output | NUM_PAIRS*CODE_W | Codes to the positive-only converters |
| out_swap_o | output | NUM_PAIRS | Per-pair output exchange select |

## Verification
The bench runs a sequence of line strobes, frame strobes and simultaneous strobes, and checks polarity and routing after each one.

- **Simultaneous strobes:** a design that lets the line strobe win would leave the wrong starting polarity for the next frame.
- **Idle cycles with changing codes:** a design that captured codes on every cycle would route data from another line.
- **All-ones and all-zeros codes on different pairs:** these expose a truncated or sign-extended decoder path, and cross-talk between pairs.
- **Reset:** a wrong reset value would start the first line in the crossed order.

// File: rtl/dotinv_pkg.sv
package dotinv_pkg;

    typedef enum logic [0:0] {
        POL_NORMAL  = 1'b0,
        POL_CROSSED = 1'b1
    } pol_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LINE  = 2'd1,
        EV_FRAME = 2'd2
    } strobe_ev_e;

endpackage

// File: rtl/dotinv_pol_fsm.sv
module dotinv_pol_fsm
    import dotinv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_stb_i,
    input  logic frame_stb_i,
    output logic pol_o,
    output logic load_o
);

    pol_state_e state_q, state_d;
    logic       frame_start_q, frame_start_d;
    strobe_ev_e ev;

    // strobe classification: frame has priority
    always_comb begin
        if (frame_stb_i)      ev = EV_FRAME;
        else if (line_stb_i)  ev = EV_LINE;
        else                  ev = EV_NONE;
    end

    // next-state logic
    always_comb begin
        state_d       = state_q;
        frame_start_d = frame_start_q;
        unique case (ev)
            EV_FRAME: begin
                frame_start_d = ~frame_start_q;
                state_d       = frame_start_d ? POL_CROSSED : POL_NORMAL;
            end
            EV_LINE: begin
                state_d = (state_q == POL_NORMAL) ? POL_CROSSED : POL_NORMAL;
            end
            default: begin
                state_d       = state_q;
                frame_start_d = frame_start_q;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= POL_NORMAL;
            frame_start_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            frame_start_q <= frame_start_d;
        end
    end

    // outputs
    always_comb begin
        pol_o  = (state_q == POL_CROSSED);
        load_o = (ev != EV_NONE);
    end

    // R2
    line_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb_i && !frame_stb_i) |=> (pol_o != $past(pol_o)));

    // R3
    frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb_i |=> ((frame_start_q != $past(frame_start_q)) && (pol_o == frame_start_q)));

    // R7
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_stb_i && !frame_stb_i) |=> $stable(pol_o));

endmodule

// File: rtl/dotinv_code_latch.sv
module dotinv_code_latch #(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CODE_W-1:0] d_i,
    output logic [CODE_W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(q_o));

endmodule

// File: rtl/dotinv_pair_swap.sv
module dotinv_pair_swap #(
    parameter int CODE_W = 10
) (
    input  logic              cross_i,
    input  logic [CODE_W-1:0] odd_i,
    input  logic [CODE_W-1:0] even_i,
    output logic [CODE_W-1:0] neg_o,
    output logic [CODE_W-1:0] pos_o,
    output logic              swap_o
);

    always_comb begin
        if (cross_i) begin
            neg_o = even_i;
            pos_o = odd_i;
        end else begin
            neg_o = odd_i;
            pos_o = even_i;
        end
        swap_o = cross_i;
    end

endmodule

// File: rtl/dotinv_pair_router.sv
module dotinv_pair_router #(
    parameter int CODE_W    = 10,
    parameter int NUM_PAIRS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        line_stb_i,
    input  logic                        frame_stb_i,
    input  logic [NUM_PAIRS*CODE_W-1:0] odd_codes_i,
    input  logic [NUM_PAIRS*CODE_W-1:0] even_codes_i,
    output logic                        pol_o,
    output logic [NUM_PAIRS*CODE_W-1:0] neg_codes_o,
    output logic [NUM_PAIRS*CODE_W-1:0] pos_codes_o,
    output logic [NUM_PAIRS-1:0]        out_swap_o
);

    localparam int BUS_W = NUM_PAIRS * CODE_W;

    logic             load;
    logic [BUS_W-1:0] odd_q;
    logic [BUS_W-1:0] even_q;

    dotinv_pol_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_stb_i  (line_stb_i),
        .frame_stb_i (frame_stb_i),
        .pol_o       (pol_o),
        .load_o      (load)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        dotinv_code_latch #(.CODE_W(CODE_W)) u_odd (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .d_i    (odd_codes_i[p*CODE_W +: CODE_W]),
            .q_o    (odd_q[p*CODE_W +: CODE_W])
        );

        dotinv_code_latch #(.CODE_W(CODE_W)) u_even (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load),
            .d_i    (even_codes_i[p*CODE_W +: CODE_W]),
            .q_o    (even_q[p*CODE_W +: CODE_W])
        );

        dotinv_pair_swap #(.CODE_W(CODE_W)) u_swap (
            .cross_i (pol_o),
            .odd_i   (odd_q[p*CODE_W +: CODE_W]),
            .even_i  (even_q[p*CODE_W +: CODE_W]),
            .neg_o   (neg_codes_o[p*CODE_W +: CODE_W]),
            .pos_o   (pos_codes_o[p*CODE_W +: CODE_W]),
            .swap_o  (out_swap_o[p])
        );

        // R8
        pair_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ({neg_codes_o[p*CODE_W +: CODE_W], pos_codes_o[p*CODE_W +: CODE_W]}
                 == {odd_q[p*CODE_W +: CODE_W], even_q[p*CODE_W +: CODE_W]})
            || ({neg_codes_o[p*CODE_W +: CODE_W], pos_codes_o[p*CODE_W +: CODE_W]}
                 == {even_q[p*CODE_W +: CODE_W], odd_q[p*CODE_W +: CODE_W]}));

        // R6
        swap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_swap_o[p] == pol_o);
    end

endmodule

// File: tb/dotinv_pair_router_tb.sv
`timescale 1ns/1ps
module dotinv_pair_router_tb;

    localparam int CODE_W    = 10;
    localparam int NUM_PAIRS = 4;
    localparam int BUS_W     = CODE_W * NUM_PAIRS;
    localparam int CMAX      = (1 << CODE_W) - 1;
    localparam int NVEC      = 12;

    // {line, frame, expected pol}
    localparam logic [2:0] VEC [NVEC] = '{
        3'b101, 3'b100, 3'b101, 3'b011, 3'b100, 3'b000,
        3'b101, 3'b110, 3'b101, 3'b011, 3'b010, 3'b101
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             line_stb = 1'b0;
    logic             frame_stb = 1'b0;
    logic [BUS_W-1:0] odd_codes = '0;
    logic [BUS_W-1:0] even_codes = '0;
    logic             pol;
    logic [BUS_W-1:0] neg_codes;
    logic [BUS_W-1:0] pos_codes;
    logic [NUM_PAIRS-1:0] out_swap;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int exp_odd  [NUM_PAIRS];
    int exp_even [NUM_PAIRS];

    always #2.5 clk = ~clk;

    dotinv_pair_router #(.CODE_W(CODE_W), .NUM_PAIRS(NUM_PAIRS)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_stb_i   (line_stb),
        .frame_stb_i  (frame_stb),
        .odd_codes_i  (odd_codes),
        .even_codes_i (even_codes),
        .pol_o        (pol),
        .neg_codes_o  (neg_codes),
        .pos_codes_o  (pos_codes),
        .out_swap_o   (out_swap)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_route(input string req, input int exp_pol);
        chk(req, "pol", int'(pol), exp_pol);
        chk("R6", "out_swap", int'(out_swap), exp_pol ? (1 << NUM_PAIRS) - 1 : 0);
        for (int p = 0; p < NUM_PAIRS; p++) begin
            chk(req, "neg code", int'(neg_codes[p*CODE_W +: CODE_W]),
                exp_pol ? exp_even[p] : exp_odd[p]);
            chk(req, "pos code", int'(pos_codes[p*CODE_W +: CODE_W]),
                exp_pol ? exp_odd[p] : exp_even[p]);
        end
    endtask

    task automatic set_codes(input int seed);
        for (int p = 0; p < NUM_PAIRS; p++) begin
            odd_codes[p*CODE_W +: CODE_W]  = CODE_W'((seed * 97 + p * 31 + 5) % (CMAX + 1));
            even_codes[p*CODE_W +: CODE_W] = CODE_W'((seed * 53 + p * 211 + 900) % (CMAX + 1));
        end
    endtask

    task automatic capture_expect();
        for (int p = 0; p < NUM_PAIRS; p++) begin
            exp_odd[p]  = int'(odd_codes[p*CODE_W +: CODE_W]);
            exp_even[p] = int'(even_codes[p*CODE_W +: CODE_W]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int cur_pol;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            exp_odd[p]  = 0;
            exp_even[p] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check_route("R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_route("R1", 0);

        // table walk: R2 line, R3 frame, R7 idle, R4/R5 routing
        cur_pol = 0;
        for (int i = 0; i < NVEC; i++) begin
            string req;
            line_stb  = VEC[i][2];
            frame_stb = VEC[i][1];
            set_codes(i + 1);
            if (line_stb || frame_stb) capture_expect();
            @(negedge clk);
            line_stb  = 1'b0;
            frame_stb = 1'b0;
            cur_pol = int'(VEC[i][0]);
            if (VEC[i][1])      req = "R3";
            else if (VEC[i][2]) req = "R2";
            else                req = "R7";
            chk(req, "pol step", int'(pol), cur_pol);
            check_route(cur_pol != 0 ? "R5" : "R4", cur_pol);
        end

        // R7: codes change with no strobe for several cycles
        for (int k = 0; k < 3; k++) begin
            set_codes(100 + k);
            @(negedge clk);
            check_route("R7", cur_pol);
        end

        // R8: extreme codes, distinct per pair, in both polarities
        for (int p = 0; p < NUM_PAIRS; p++) begin
            odd_codes[p*CODE_W +: CODE_W]  = (p % 2 == 0) ? CODE_W'(CMAX) : '0;
            even_codes[p*CODE_W +: CODE_W] = (p % 2 == 0) ? '0 : CODE_W'(CMAX);
        end
        capture_expect();
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        cur_pol = 1 - cur_pol;
        check_route("R8", cur_pol);
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        cur_pol = 1 - cur_pol;
        check_route("R8", cur_pol);

        // R1: reset mid-run returns to normal order and zero codes
        rst_n = 1'b0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            exp_odd[p]  = 0;
            exp_even[p] = 0;
        end
        @(negedge clk);
        check_route("R1", 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule